// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Expander

This block is an I2C target that gives a host eight general-purpose pins with no direction register. The host writes a byte to set the output latch and reads a byte to get the sampled pin levels. A latch bit of 1 drives only a weak pullup, so the external world can pull that pin low and the pin works as an input. A latch bit of 0 drives the pin low. Whether a pin is an input or an output therefore depends only on the value last written to it.

SCL and SDA arrive as raw oversampled levels and pass through synchronizers. The block detects START and STOP, matches its 7-bit address, acknowledges, and shifts bytes in and out. It drives SDA only through a pull-low output and never starts a transaction. When a write raises a latch bit from 0 to 1, that bit gets a short strong-pullup pulse so that a heavily loaded pin rises quickly. The next falling edge of SCL ends the pulse. The analog pad, the current drivers and any interrupt output are outside this block.

Top module: `qbpx_target`

## Requirements
- R1: After reset the latch reads 8'hFF, every weak-pullup enable is 1, every strong-pullup enable is 0 and SDA is not pulled low.
- R2: The target answers only the 7-bit address {4'b0111, addr_sel[2:0]}, sent MSB first and followed by the R/W bit (0 = write, 1 = read). On a match it pulls SDA low for the ninth clock. On a mismatch it gives no ACK, and the bytes that follow have no effect.
- R3: In a write transaction every data byte is ACKed and copied into the latch at the SCL falling edge that ends its ACK. Several bytes may follow one address. The latch holds its value at all other times.
- R4: When a byte is loaded, the strong-pullup enable turns on for exactly those bits that go from 0 to 1. A bit that is 0 in the latch never has its strong pullup on.
- R5: The strong-pullup enables clear at the next SCL falling edge after the load.
- R6: The weak-pullup enable of each bit equals its latch bit.
- R7: In a read transaction the target captures port_in at the SCL falling edge that ends the address ACK, or the host's ACK of the previous byte. It then shifts the byte out MSB first and pulls SDA low for 0 bits. Because a bit latched at 0 holds its pin low, that bit reads back as 0. A host ACK continues the read. A host NACK releases SDA and ends the transaction.
- R8: A START (SDA falls while SCL is high) restarts address reception from any state, including partway through a byte. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released. SCL clocks received in idle are ignored.
- R9: sda_pull_low changes only in the cycle after a synchronized SCL falling edge, START or STOP, so it is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull_low | output | 1 | 1 = pull SDA low (open-drain drive) |
| addr_sel | input | 3 | Low three bits of the target address |
| port_in | input | 8 | Sampled pin levels |
| port_latch | output | 8 | Output latch: 0 drives the pin low |
| weak_pu_en | output | 8 | Per-bit weak pullup enable |
| strong_pu_en | output | 8 | Per-bit strong pullup pulse enable |

## Verification
The bench aims at these corner cases:
- **Strong-pullup mask.** A write that mixes 0-to-1, 1-to-0 and unchanged bits checks that only the rising bits get the pulse. A design that used the written value instead of the change would pulse bits that were already high.
- **Read capture point.** The pin levels change halfway through a read byte. A target that sampled per bit, or captured late, would return a mixed byte.
- **Latched-0 readback.** A bit latched at 0 must read back as 0 even while the outside drives it high.
- **Restart and idle.** A repeated START in the middle of a data byte must abandon the partial byte. Clocks after a STOP must not be taken as data.
- **Address and NACK.** A wrong address, or a NACK from the host, must leave SDA released. A design that kept driving would hang the bus.

// File: rtl/qbpx_pkg.sv
package qbpx_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int PFX_W  = 7 - SEL_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } bus_state_t;
endpackage

// File: rtl/qbpx_busin.sv
module qbpx_busin #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_w;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] lvl_q;

  assign raw_w = {sda_raw, scl_raw};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] pipe;
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[SYNC_STAGES-2:0], raw_w[g]};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= raw_w[g];
      end
    end
    assign lvl[g] = pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  assign sda_lvl   = lvl[1];
  assign scl_rise  =  lvl[0] & ~lvl_q[0];
  assign scl_fall  = ~lvl[0] &  lvl_q[0];
  assign start_det =  lvl_q[1] & ~lvl[1] & lvl[0] & lvl_q[0];
  assign stop_det  = ~lvl_q[1] &  lvl[1] & lvl[0] & lvl_q[0];
endmodule

// File: rtl/qbpx_proto.sv
module qbpx_proto
  import qbpx_pkg::*;
#(
  parameter logic [PFX_W-1:0] ADDR_PREFIX = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic [BYTE_W-1:0] pins,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_pull
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_t        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              rw, rw_n;
  logic              oe, oe_n;
  logic              nack, nack_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    sh_n   = sh;
    rw_n   = rw;
    oe_n   = oe;
    nack_n = nack;
    wr_stb = 1'b0;
    if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt + CNT_W'(1);
          end else if (scl_fall && cnt == FULL) begin
            if (st == ST_WDATA) begin
              st_n = ST_WACK;
              oe_n = 1'b1;
            end else if (sh[BYTE_W-1:1] == {ADDR_PREFIX, addr_sel}) begin
              st_n = ST_AACK;
              rw_n = sh[0];
              oe_n = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              st_n = ST_RDATA;
              sh_n = pins;
              oe_n = ~pins[BYTE_W-1];
            end else begin
              st_n = ST_WDATA;
              oe_n = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            wr_stb = 1'b1;
            st_n   = ST_WDATA;
            cnt_n  = '0;
            oe_n   = 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt == FULL) begin
              st_n = ST_RACK;
              oe_n = 1'b0;
            end else begin
              sh_n = {sh[BYTE_W-2:0], 1'b0};
              oe_n = ~sh[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_n = sda_lvl;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (nack) begin
              st_n = ST_IDLE;
              oe_n = 1'b0;
            end else begin
              st_n = ST_RDATA;
              sh_n = pins;
              oe_n = ~pins[BYTE_W-1];
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      sh   <= '0;
      rw   <= 1'b0;
      oe   <= 1'b0;
      nack <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      sh   <= sh_n;
      rw   <= rw_n;
      oe   <= oe_n;
      nack <= nack_n;
    end
  end

  assign wr_data  = sh;
  assign sda_pull = oe;
endmodule

// File: rtl/qbpx_bitcell.sv
module qbpx_bitcell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic scl_fall,
  output logic latch_q,
  output logic weak_en,
  output logic strong_en
);
  logic latch_n;
  logic strong_q, strong_n;

  always_comb begin
    latch_n  = latch_q;
    strong_n = strong_q;
    if (wr_stb) begin
      latch_n  = wr_bit;
      strong_n = wr_bit & ~latch_q;
    end else if (scl_fall) begin
      strong_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= 1'b1;
      strong_q <= 1'b0;
    end else begin
      latch_q  <= latch_n;
      strong_q <= strong_n;
    end
  end

  assign weak_en   = latch_q;
  assign strong_en = strong_q;
endmodule

// File: rtl/qbpx_target.sv
module qbpx_target
  import qbpx_pkg::*;
#(
  parameter logic [PFX_W-1:0] ADDR_PREFIX = 4'b0111,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic [BYTE_W-1:0] port_in,
  output logic [BYTE_W-1:0] port_latch,
  output logic [BYTE_W-1:0] weak_pu_en,
  output logic [BYTE_W-1:0] strong_pu_en
);
  logic              rst_q1, rst_q2;
  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  qbpx_busin #(.SYNC_STAGES(SYNC_STAGES)) i_busin (
    .clk       (clk),
    .rst_n     (rst_q2),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  qbpx_proto #(.ADDR_PREFIX(ADDR_PREFIX)) i_proto (
    .clk       (clk),
    .rst_n     (rst_q2),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel),
    .pins      (port_in),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .sda_pull  (sda_pull_low)
  );

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    qbpx_bitcell i_cell (
      .clk       (clk),
      .rst_n     (rst_q2),
      .wr_stb    (wr_stb),
      .wr_bit    (wr_data[b]),
      .scl_fall  (scl_fall),
      .latch_q   (port_latch[b]),
      .weak_en   (weak_pu_en[b]),
      .strong_en (strong_pu_en[b])
    );
  end
endmodule

// File: rtl/qbpx_checker.sv
module qbpx_checker
  import qbpx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_stb,
  input logic              sda_pull_low,
  input logic [BYTE_W-1:0] port_latch,
  input logic [BYTE_W-1:0] strong_pu_en
);
  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(port_latch));

  // R4
  strong_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_pu_en & ~port_latch) == '0);

  // R4
  strong_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((strong_pu_en & ~$past(strong_pu_en)) != '0) |-> $past(wr_stb));

  // R5
  strong_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !wr_stb) |=> (strong_pu_en == '0));

  // R9
  sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_low != $past(sda_pull_low)) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind qbpx_target qbpx_checker i_qbpx_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_fall     (scl_fall),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .wr_stb       (wr_stb),
  .sda_pull_low (sda_pull_low),
  .port_latch   (port_latch),
  .strong_pu_en (strong_pu_en)
);

// File: tb/test_qbpx_target.sv
`timescale 1ns/1ps
module test_qbpx_target;
  localparam int HP = 10;
  localparam logic [7:0] WR_ADDR = 8'h7A;  // {0111,101,0}
  localparam logic [7:0] RD_ADDR = 8'h7B;  // {0111,101,1}
  localparam int NVEC = 6;
  // {data byte, expected strong-pullup mask}
  localparam logic [15:0] WR_VEC [NVEC] = '{16'h00_00, 16'hA5_A5, 16'hFF_5A,
                                            16'h3C_00, 16'h7E_42, 16'h81_81};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic [7:0] ext_pins = 8'hFF;
  logic [2:0] addr_sel = 3'b101;
  logic       sda_pull_low;
  logic [7:0] port_latch, weak_pu_en, strong_pu_en;
  wire        sda_line = sda_drv & ~sda_pull_low;
  wire  [7:0] port_in  = port_latch & ext_pins;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  qbpx_target i_qbpx_target (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_drv),
    .sda_in       (sda_line),
    .sda_pull_low (sda_pull_low),
    .addr_sel     (addr_sel),
    .port_in      (port_in),
    .port_latch   (port_latch),
    .weak_pu_en   (weak_pu_en),
    .strong_pu_en (strong_pu_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; hp();
    scl_drv = 1'b1; hp();
    sda_drv = 1'b0; hp();
    scl_drv = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; hp();
    scl_drv = 1'b1; hp();
    sda_drv = 1'b1; hp();
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; hp();
    scl_drv = 1'b1; hp(); hp();
    scl_drv = 1'b0; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; hp();
    scl_drv = 1'b1; hp();
    ack = ~sda_line;
    hp();
    scl_drv = 1'b0; hp();
  endtask

  task automatic recv_byte(input logic nack, input logic chg, input logic [7:0] new_ext,
                           output logic [7:0] d);
    logic a;
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp();
      scl_drv = 1'b1; hp();
      a = sda_pull_low;
      d[i] = sda_line;
      hp();
      chk(a == sda_pull_low, "R9 sda stable while SCL high", int'(sda_pull_low), int'(a));
      scl_drv = 1'b0;
      if (chg && i == 4) ext_pins = new_ext;
    end
    hp();
    sda_drv = nack; hp();
    scl_drv = 1'b1; hp(); hp();
    scl_drv = 1'b0; hp();
    sda_drv = 1'b1;
  endtask

  task automatic write_one(input logic [7:0] d);
    logic ack;
    i2c_start();
    send_byte(WR_ADDR, ack);
    send_byte(d, ack);
    i2c_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic       ack;
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state
    chk(port_latch == 8'hFF, "R1 latch", int'(port_latch), 8'hFF);
    chk(weak_pu_en == 8'hFF, "R1 weak", int'(weak_pu_en), 8'hFF);
    chk(strong_pu_en == 8'h00, "R1 strong", int'(strong_pu_en), 0);
    chk(sda_pull_low == 1'b0, "R1 sda", int'(sda_pull_low), 0);

    // Table of single-byte writes
    for (int v = 0; v < NVEC; v++) begin
      i2c_start();
      chk(strong_pu_en == 8'h00, "R5 strong cleared by SCL fall", int'(strong_pu_en), 0);
      send_byte(WR_ADDR, ack);
      chk(ack, "R2 address ACK", int'(ack), 1);
      send_byte(WR_VEC[v][15:8], ack);
      chk(ack, "R3 data ACK", int'(ack), 1);
      chk(port_latch == WR_VEC[v][15:8], "R3 latch load", int'(port_latch), int'(WR_VEC[v][15:8]));
      chk(strong_pu_en == WR_VEC[v][7:0], "R4 strong mask", int'(strong_pu_en), int'(WR_VEC[v][7:0]));
      chk(weak_pu_en == WR_VEC[v][15:8], "R6 weak follows latch", int'(weak_pu_en), int'(WR_VEC[v][15:8]));
      i2c_stop();
    end

    // R2: wrong address (sel 110) gets no ACK and no effect
    i2c_start();
    send_byte(8'h7C, ack);
    chk(!ack, "R2 mismatch no ACK", int'(ack), 0);
    send_byte(8'h00, ack);
    chk(!ack, "R2 mismatch data no ACK", int'(ack), 0);
    i2c_stop();
    chk(port_latch == 8'h81, "R2 mismatch latch kept", int'(port_latch), 8'h81);

    // R3: several bytes after one address
    i2c_start();
    send_byte(WR_ADDR, ack);
    send_byte(8'h0F, ack);
    chk(port_latch == 8'h0F, "R3 multi byte 1", int'(port_latch), 8'h0F);
    send_byte(8'hFF, ack);
    chk(port_latch == 8'hFF, "R3 multi byte 2", int'(port_latch), 8'hFF);
    chk(strong_pu_en == 8'hF0, "R4 multi strong", int'(strong_pu_en), 8'hF0);
    i2c_stop();

    // R7: read with capture at ACK, pins change mid-byte
    ext_pins = 8'h5A;
    i2c_start();
    send_byte(RD_ADDR, ack);
    chk(ack, "R2 read address ACK", int'(ack), 1);
    recv_byte(1'b0, 1'b1, 8'hC3, rd);
    chk(rd == 8'h5A, "R7 read byte 1", int'(rd), 8'h5A);
    recv_byte(1'b1, 1'b0, 8'h00, rd);
    chk(rd == 8'hC3, "R7 read byte 2", int'(rd), 8'hC3);
    chk(sda_pull_low == 1'b0, "R7 NACK releases SDA", int'(sda_pull_low), 0);
    ext_pins = 8'h00;
    send_byte(8'hFF, ack);
    chk(!ack, "R7 no drive after NACK", int'(ack), 0);
    i2c_stop();

    // R7: a latched 0 reads back 0
    write_one(8'h0F);
    ext_pins = 8'hFF;
    i2c_start();
    send_byte(RD_ADDR, ack);
    recv_byte(1'b1, 1'b0, 8'h00, rd);
    chk(rd == 8'h0F, "R7 latched zero reads 0", int'(rd), 8'h0F);
    i2c_stop();

    // R8: repeated START partway through a data byte
    i2c_start();
    send_byte(WR_ADDR, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_start();
    send_byte(WR_ADDR, ack);
    chk(ack, "R8 restart address ACK", int'(ack), 1);
    send_byte(8'h99, ack);
    chk(port_latch == 8'h99, "R8 restart write", int'(port_latch), 8'h99);
    i2c_stop();

    // R8: STOP returns to idle; later clocks are ignored
    i2c_start();
    send_byte(WR_ADDR, ack);
    i2c_stop();
    chk(sda_pull_low == 1'b0, "R8 STOP releases SDA", int'(sda_pull_low), 0);
    send_byte(8'h00, ack);
    chk(!ack, "R8 idle no ACK", int'(ack), 0);
    chk(port_latch == 8'h99, "R8 idle latch kept", int'(port_latch), 8'h99);
    i2c_stop();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule